// File: doc/BRIEF.md
# Recursive Carry-Select Adder

This block is a purely combinational adder. It takes two N-bit operands and a carry-in and returns an N-bit sum and a carry-out. It has no clock and no reset. Outputs follow the inputs within the same cycle, so the block can sit between registers anywhere in a datapath.

Internally the operand width is halved. The low half is added with the incoming carry. Two copies of the high-half adder run side by side, one assuming a carry of 0 and one assuming a carry of 1. The carry leaving the low half then picks one of the two high results through 2-to-1 multiplexers. Each half is split again in the same way until a piece is L bits wide. A piece of that width is a plain ripple-carry adder.

The recursion trades area for delay. Each level roughly triples the adder cells below it, while the carry path crosses only one multiplexer per level plus one leaf.

Top module: `carry_select_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_o, sum_o} equals the (N+1)-bit sum of a_i, b_i and carry_i.
- R2: The low N/2 bits of sum_o equal the low N/2 bits of a_i[N/2-1:0] + b_i[N/2-1:0] + carry_i, whatever the upper operand bits are.
- R3: With a_i all ones, b_i zero and carry_i = 1, sum_o is zero and carry_o is 1.
- R4: With b_i zero and carry_i = 0, sum_o equals a_i and carry_o is 0. With all inputs zero, all outputs are zero.
- R5: A carry generated in the low half reaches the high half. With a_i = 2^(N/2)-1, b_i = 0 and carry_i = 1, sum_o = 2^(N/2) and carry_o = 0.
- R6: A carry generated only in the top bit sets carry_o. With a_i = b_i = 2^(N-1) and carry_i = 0, sum_o is zero and carry_o is 1.
- R7: The block holds no state. The outputs settle to the value for the current inputs within the cycle in which those inputs are applied, whatever inputs came before.
- R8: N must equal L times a power of two, with L at least 1. Pieces of width L are ripple-carry adders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| carry_o | output | 1 | Carry out of bit N-1 |

## Verification
The directed patterns each target one kind of carry path:
- All ones plus a carry ripples through every leaf and every select level.
- A low half of ones with carry-in 1 tests only the first-level select.
- Two top-bit operands produce a carry-out with no internal carry.
- Adding zero shows that the speculative copies do not disturb a sum that has no carry.

Alternating-bit pairs place carries at every leaf boundary. Random pairs with both carry-in values cover the mixed cases. For every vector the full result and the low half are compared separately, so an error in high-half selection can be told apart from an error in the low adder.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Legal when n == l * 2^k with l >= 1
  function automatic bit width_ok(int n, int l);
    int w;
    if (l < 1 || n < l) return 1'b0;
    w = n;
    while (w > l) begin
      if (w % 2 != 0) return 1'b0;
      w = w / 2;
    end
    return (w == l);
  endfunction

  function automatic int split_levels(int n, int l);
    int k;
    int w;
    k = 0;
    w = n;
    while (w > l) begin
      w = w / 2;
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/csa_ripple_leaf.sv
module csa_ripple_leaf #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);

  logic [W:0] c;

  always_comb begin
    c[0] = ci_i;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
      c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
  end

  assign co_o = c[W];

endmodule

// File: rtl/csa_sel_mux.sv
module csa_sel_mux #(
  parameter int W = 4
) (
  input  logic         sel_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  output logic [W-1:0] y_o
);

  assign y_o = sel_i ? d1_i : d0_i;

endmodule

// File: rtl/csa_node.sv
module csa_node #(
  parameter int W = 32,
  parameter int L = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);

  localparam int H = (W > L) ? W / 2 : W;

  if (W <= L) begin : g_leaf
    csa_ripple_leaf #(.W(W)) u_leaf (
      .a_i  (a_i),
      .b_i  (b_i),
      .ci_i (ci_i),
      .sum_o(sum_o),
      .co_o (co_o)
    );
  end else begin : g_split
    logic [H-1:0] lo_sum, hi_sum0, hi_sum1;
    logic         lo_co, hi_co0, hi_co1;

    csa_node #(.W(H), .L(L)) u_lo (
      .a_i  (a_i[H-1:0]),
      .b_i  (b_i[H-1:0]),
      .ci_i (ci_i),
      .sum_o(lo_sum),
      .co_o (lo_co)
    );

    // speculative upper halves
    csa_node #(.W(H), .L(L)) u_hi0 (
      .a_i  (a_i[W-1:H]),
      .b_i  (b_i[W-1:H]),
      .ci_i (1'b0),
      .sum_o(hi_sum0),
      .co_o (hi_co0)
    );

    csa_node #(.W(H), .L(L)) u_hi1 (
      .a_i  (a_i[W-1:H]),
      .b_i  (b_i[W-1:H]),
      .ci_i (1'b1),
      .sum_o(hi_sum1),
      .co_o (hi_co1)
    );

    logic [H:0] hi_sel;

    csa_sel_mux #(.W(H+1)) u_mux (
      .sel_i(lo_co),
      .d0_i ({hi_co0, hi_sum0}),
      .d1_i ({hi_co1, hi_sum1}),
      .y_o  (hi_sel)
    );

    assign sum_o = {hi_sel[H-1:0], lo_sum};
    assign co_o  = hi_sel[H];
  end

endmodule

// File: rtl/carry_select_adder.sv
module carry_select_adder #(
  parameter int N = 32,
  parameter int L = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         carry_i,
  output logic [N-1:0] sum_o,
  output logic         carry_o
);

  localparam int Levels = csa_pkg::split_levels(N, L);

  if (!csa_pkg::width_ok(N, L)) begin : g_bad_width
    $error("carry_select_adder: N=%0d is not L=%0d times a power of two (levels %0d)",
           N, L, Levels);
  end

  csa_node #(.W(N), .L(L)) u_root (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (carry_i),
    .sum_o(sum_o),
    .co_o (carry_o)
  );

endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
  parameter int N = 32
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         carry_i,
  input logic [N-1:0] sum_o,
  input logic         carry_o
);

  localparam int H = N / 2;

  logic [N:0] full;
  logic [H:0] low;

  always_comb begin
    full = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, carry_i};
    low  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, carry_i};

    p_total_r1: assert ({carry_o, sum_o} == full)
      else $error("R1 sum mismatch");
    p_low_half_r2: assert (sum_o[H-1:0] == low[H-1:0])
      else $error("R2 low half mismatch");
    if (&a_i && b_i == '0 && carry_i) begin
      p_all_ones_r3: assert (sum_o == '0 && carry_o)
        else $error("R3 wrap failed");
    end
    if (b_i == '0 && !carry_i) begin
      p_add_zero_r4: assert (sum_o == a_i && !carry_o)
        else $error("R4 identity failed");
    end
    if (a_i[N-1] && b_i[N-1] && a_i[N-2:0] == '0 && b_i[N-2:0] == '0 && !carry_i) begin
      p_top_carry_r6: assert (sum_o == '0 && carry_o)
        else $error("R6 top carry failed");
    end
  end

endmodule

bind carry_select_adder csa_checker #(.N(N)) u_csa_checker (
  .a_i    (a_i),
  .b_i    (b_i),
  .carry_i(carry_i),
  .sum_o  (sum_o),
  .carry_o(carry_o)
);

// File: tb/carry_select_adder_tb.sv
module carry_select_adder_tb_top;

  localparam int N = 32;
  localparam int L = 4;
  localparam int H = N / 2;
  localparam int WatchdogCycles = 100000;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         c;
    string        tag;
  } vec_t;

  logic         clk;
  logic [N-1:0] a_i, b_i, sum_o;
  logic         carry_i, carry_o;
  int           n_checks, n_errors, cycles;
  bit           done;
  vec_t         vq[$];

  carry_select_adder #(.N(N), .L(L)) dut_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .carry_i(carry_i),
    .sum_o  (sum_o),
    .carry_o(carry_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] r;
    for (int i = 0; i < N; i += 32) r = {r, 32'($urandom())};
    return r;
  endfunction

  task automatic check_eq(string req, logic [N:0] act, logic [N:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [N-1:0] a, logic [N-1:0] b, logic c, string tag);
    vec_t v;
    v.a = a; v.b = b; v.c = c; v.tag = tag;
    vq.push_back(v);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WatchdogCycles && !done) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WatchdogCycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [N:0] exp_full;
    logic [H:0] exp_low;
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    a_i = '0; b_i = '0; carry_i = 1'b0;

    @(negedge clk);
    // R4 start-up state with zero inputs
    check_eq("R4 idle", {carry_o, sum_o}, '0);

    push('1, '0, 1'b1, "R3 all ones plus carry");
    push('1, '1, 1'b1, "R3 all ones twice plus carry");
    push({{H{1'b0}}, {H{1'b1}}}, '0, 1'b1, "R5 low half carry");
    push({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0, "R6 top carry");
    push(32'h1234_5678, '0, 1'b0, "R4 add zero");
    push('1, '0, 1'b0, "R4 add zero ones");
    push(32'h5555_5555, 32'h5555_5555, 1'b1, "R1 alternating");
    push(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R1 complement");
    push(32'h0000_000F, 32'h0000_0001, 1'b0, "R1 leaf boundary");
    push(32'h00FF_FFFF, 32'h0000_0000, 1'b1, "R1 deep ripple");
    push(32'hDEAD_0000, 32'h0000_BEEF, 1'b1, "R2 upper noise");
    push(32'h0000_0000, 32'h0000_0000, 1'b0, "R7 back to zero");
    for (int i = 0; i < 200; i++) push(rnd(), rnd(), 1'($urandom()), "R1 random");

    while (vq.size() > 0) begin
      vec_t v;
      v = vq.pop_front();
      @(posedge clk);
      a_i = v.a; b_i = v.b; carry_i = v.c;
      @(negedge clk);
      exp_full = {1'b0, v.a} + {1'b0, v.b} + {{N{1'b0}}, v.c};
      exp_low  = {1'b0, v.a[H-1:0]} + {1'b0, v.b[H-1:0]} + {{H{1'b0}}, v.c};
      // R1 and R7: full result settled in the same cycle
      check_eq(v.tag, {carry_o, sum_o}, exp_full);
      // R2: low half independent of upper bits
      check_eq("R2 low half", {{(N-H+1){1'b0}}, sum_o[H-1:0]},
               {{(N-H+1){1'b0}}, exp_low[H-1:0]});
    end

    // R8: default widths are a legal leaf multiple, checked through the sum of a wide carry chain
    @(posedge clk);
    a_i = {{(N-L){1'b0}}, {L{1'b1}}}; b_i = '0; carry_i = 1'b1;
    @(negedge clk);
    check_eq("R8 leaf carry", {carry_o, sum_o}, (N+1)'(1) << L);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule